// File: doc/BRIEF.md
# External Interrupt Sense and Capture Unit

This unit turns four asynchronous external interrupt pins into clean interrupt requests. Every pin is first brought into the clock domain. It is then qualified by a two-bit sense type, which selects active-high level, active-low level, rising edge or falling edge. Edges are caught in a sticky capture flop, and software releases that flop by writing a one to the pin's acknowledge bit. Levels pass straight through with the selected polarity. Each pin has its own enable, and one master enable gates all four requests.

All configuration lives in a single 32-bit control word on a simple write-strobe / read-data register port. The per-pin fields run downward as the pin index rises: sense for pin n at bits (23-2n):(22-2n), enable at bit 11-n, acknowledge at bit 27-n. Bit 12 is the master enable. Bit 0 chooses whether the critical interrupt is routed the normal way. A downstream priority encoder consumes the four request outputs and the routing bit.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted, and right after it, the control word reads 0x00000000, all requests are 0 and the routing output is 0.
- R2: A write stores the sense field of pin n in bits (23-2n):(22-2n), and reading returns it. Encoding: 0 = active-high level, 1 = rising edge, 2 = falling edge, 3 = active-low level.
- R3: Bit 11-n is the enable of pin n. When it is 0, that pin's request is 0 whatever the pin does.
- R4: Bit 12 is the master enable. When it is 0, all four requests are 0.
- R5: For a level-type pin, the request follows the pin, inverted for sense 3. A pin change driven between clock edges shows at the request after the second following edge and not after the first.
- R6: For an edge-type pin, a matching edge sets a capture flop, and the request shows after the third edge following the pin change. The capture holds after the pin returns and while the request is gated off.
- R7: Writing 1 to bit 27-n clears the capture of pin n in the cycle of the write and leaves the other pins untouched. Bits 27:24 always read 0.
- R8: If an acknowledge write and a new matching edge on the same pin fall in the same cycle, the capture stays set.
- R9: An acknowledge write to a level-type pin does not change its request.
- R10: Bit 0 is stored and driven on the routing output. Bits with no function read as 0, so writing 0xFFFFFFFF reads back 0x00FF1F01.
- R11: An edge that arrives while the pin's enable is 0 is still captured and raises the request once the enable is set.
- R12: Switching a pin to a level sense discards its capture, so switching back to an edge sense shows no request until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 4 | Raw external interrupt pins, asynchronous |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| irq_req_o | output | 4 | Conditioned interrupt request per pin |
| crit_normal_o | output | 1 | Critical interrupt routed the normal way |

## Verification
The bench targets an acknowledge write that lands in the same cycle as a fresh edge; a design that lets the clear win would drop that interrupt. It times the pipeline one edge at a time, so a missing or extra synchroniser stage shows up as a request one cycle early or late. It also catches reversed bit placement, which would make pin 0's enable or sense act on pin 3. It checks that edges are captured while masked, that leftover captures are discarded when a pin switches to level sense, and that acknowledges to level pins are ignored; a design wrong on any of these would drop, keep or invent a request.

// File: rtl/eis_pkg.sv
package eis_pkg;

  localparam int unsigned CTRL_W     = 32;
  localparam int unsigned MAX_PINS   = 4;
  localparam int unsigned MASTER_BIT = 12;
  localparam int unsigned CRIT_BIT   = 0;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  // Field positions descend as the pin index grows.
  function automatic int unsigned sense_lsb(input int unsigned n);
    return 22 - 2 * n;
  endfunction

  function automatic int unsigned en_bit(input int unsigned n);
    return 11 - n;
  endfunction

  function automatic int unsigned ack_bit(input int unsigned n);
    return 27 - n;
  endfunction

  function automatic logic is_edge(input sense_e s);
    return (s == SENSE_RISE) || (s == SENSE_FALL);
  endfunction

  // All bits that carry a function, write-only acknowledge bits included.
  function automatic logic [CTRL_W-1:0] used_mask(input int unsigned npins);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int unsigned n = 0; n < npins; n++) begin
      m[sense_lsb(n) +: 2] = 2'b11;
      m[en_bit(n)]         = 1'b1;
      m[ack_bit(n)]        = 1'b1;
    end
    m[MASTER_BIT] = 1'b1;
    m[CRIT_BIT]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = d_i;
    end else begin : g_rest
      always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eis_ctrl_reg.sv
module eis_ctrl_reg
  import eis_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [CTRL_W-1:0]         wdata_i,
  output sense_e [NPINS-1:0]        sense_o,
  output logic   [NPINS-1:0]        en_o,
  output logic                      master_o,
  output logic                      crit_o,
  output logic   [NPINS-1:0]        clr_o,
  output logic   [CTRL_W-1:0]       rdata_o
);

  localparam int unsigned SENSE_TOP = sense_lsb(0) + 1;
  localparam int unsigned SENSE_BOT = sense_lsb(NPINS - 1);
  localparam int unsigned ACK_TOP   = ack_bit(0);
  localparam int unsigned ACK_BOT   = ack_bit(NPINS - 1);
  localparam logic [CTRL_W-1:0] USED = used_mask(NPINS);

  sense_e [NPINS-1:0] sense_q, sense_d;
  logic   [NPINS-1:0] en_q, en_d;
  logic               master_q, master_d;
  logic               crit_q, crit_d;

  // Next-state values taken from the write data
  always_comb begin
    for (int unsigned n = 0; n < NPINS; n++) begin
      sense_d[n] = sense_e'(wdata_i[sense_lsb(n) +: 2]);
      en_d[n]    = wdata_i[en_bit(n)];
      clr_o[n]   = wr_i & wdata_i[ack_bit(n)];
    end
    master_d = wdata_i[MASTER_BIT];
    crit_d   = wdata_i[CRIT_BIT];
  end

  // Registers, loaded under the write strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= {NPINS{SENSE_LVL_HI}};
      en_q     <= '0;
      master_q <= 1'b0;
      crit_q   <= 1'b0;
    end else if (wr_i) begin
      sense_q  <= sense_d;
      en_q     <= en_d;
      master_q <= master_d;
      crit_q   <= crit_d;
    end
  end

  // Read view: stored fields in place, everything else zero
  always_comb begin
    rdata_o = '0;
    for (int unsigned n = 0; n < NPINS; n++) begin
      rdata_o[sense_lsb(n) +: 2] = sense_q[n];
      rdata_o[en_bit(n)]         = en_q[n];
    end
    rdata_o[MASTER_BIT] = master_q;
    rdata_o[CRIT_BIT]   = crit_q;
  end

  assign sense_o  = sense_q;
  assign en_o     = en_q;
  assign master_o = master_q;
  assign crit_o   = crit_q;

  logic unused_wdata;
  assign unused_wdata = ^(wdata_i & ~USED);

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> rdata_o[SENSE_TOP:SENSE_BOT] == $past(wdata_i[SENSE_TOP:SENSE_BOT])); // R2

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> rdata_o[ACK_TOP:ACK_BOT] == '0); // R7

  AST_ROUTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> crit_o == $past(wdata_i[CRIT_BIT])); // R10

endmodule

// File: rtl/eis_pin_cond.sv
module eis_pin_cond
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl_i,
  input  sense_e sense_i,
  input  logic   en_i,
  input  logic   master_i,
  input  logic   clr_i,
  output logic   req_o
);

  logic prev_q, prev_d;
  logic cap_q, cap_d;
  logic edge_type, rise, fall, hit, active;

  always_comb begin
    edge_type = is_edge(sense_i);
    rise      = lvl_i & ~prev_q;
    fall      = ~lvl_i & prev_q;
    hit       = ((sense_i == SENSE_RISE) & rise) | ((sense_i == SENSE_FALL) & fall);
    // A new edge outranks an acknowledge in the same cycle
    cap_d     = edge_type & (hit | (cap_q & ~clr_i));
    prev_d    = lvl_i;
    if (edge_type)                    active = cap_q;
    else if (sense_i == SENSE_LVL_LO) active = ~lvl_i;
    else                              active = lvl_i;
    req_o     = master_i & en_i & active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      cap_q  <= cap_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_i) |=> cap_q); // R8

  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_type && cap_q && !clr_i) |=> cap_q); // R6

  AST_LEVEL_DROPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_type |=> !cap_q); // R12

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int unsigned NPINS       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  ext_pin_i,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic [NPINS-1:0]  irq_req_o,
  output logic              crit_normal_o
);

  sense_e [NPINS-1:0] sense_w;
  logic   [NPINS-1:0] en_w;
  logic   [NPINS-1:0] clr_w;
  logic   [NPINS-1:0] pin_sync;
  logic               master_w;

  eis_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_pin_i),
    .q_o   (pin_sync)
  );

  eis_ctrl_reg #(
    .NPINS (NPINS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .sense_o  (sense_w),
    .en_o     (en_w),
    .master_o (master_w),
    .crit_o   (crit_normal_o),
    .clr_o    (clr_w),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    eis_pin_cond u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (pin_sync[g]),
      .sense_i  (sense_w[g]),
      .en_i     (en_w[g]),
      .master_i (master_w),
      .clr_i    (clr_w[g]),
      .req_o    (irq_req_o[g])
    );
  end

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_w |-> irq_req_o == '0); // R4

  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o & ~en_w) == '0); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (irq_req_o == '0 && reg_rdata_o == '0)); // R1

endmodule

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic [3:0]  pins;
    logic [3:0]  wait_n;
    logic [3:0]  exp;
    logic [3:0]  tag;
  } vec_t;

  // m: master, en/ack bit n = pin n, sN: sense of pin N
  function automatic logic [31:0] cw(input logic m, input logic [3:0] en,
                                     input logic [1:0] s0, input logic [1:0] s1,
                                     input logic [1:0] s2, input logic [1:0] s3,
                                     input logic [3:0] ack);
    logic [31:0] r;
    r = '0;
    r[12] = m;
    for (int n = 0; n < 4; n++) begin
      r[11-n] = en[n];
      r[27-n] = ack[n];
    end
    r[23:22] = s0; r[21:20] = s1; r[19:18] = s2; r[17:16] = s3;
    return r;
  endfunction

  localparam int NV = 18;
  localparam logic [31:0] RD_MASK = 32'h00FF1F01;
  localparam vec_t VECS [NV] = '{
    '{1'b1, cw(1,4'b1111,0,0,0,0,4'b0000), 4'b0000, 4'd2, 4'b0000, 4'd5},  // R5
    '{1'b0, 32'h0,                          4'b1010, 4'd2, 4'b1010, 4'd5},  // R5
    '{1'b1, cw(1,4'b1111,3,3,3,3,4'b0000), 4'b1010, 4'd1, 4'b0101, 4'd5},  // R5
    '{1'b1, cw(0,4'b1111,3,3,3,3,4'b0000), 4'b1010, 4'd1, 4'b0000, 4'd4},  // R4
    '{1'b1, cw(1,4'b0000,3,3,3,3,4'b0000), 4'b1010, 4'd1, 4'b0000, 4'd3},  // R3
    '{1'b1, cw(1,4'b0101,3,3,3,3,4'b0000), 4'b1010, 4'd1, 4'b0101, 4'd3},  // R3
    '{1'b1, cw(1,4'b1111,1,1,2,2,4'b0000), 4'b0011, 4'd3, 4'b1001, 4'd6},  // R6
    '{1'b0, 32'h0,                          4'b0000, 4'd3, 4'b1001, 4'd6},  // R6
    '{1'b0, 32'h0,                          4'b1111, 4'd3, 4'b1011, 4'd6},  // R6
    '{1'b1, cw(1,4'b1111,1,1,2,2,4'b1001), 4'b1111, 4'd1, 4'b0010, 4'd7},  // R7
    '{1'b1, cw(0,4'b1111,1,1,2,2,4'b0000), 4'b1111, 4'd1, 4'b0000, 4'd4},  // R4
    '{1'b1, cw(1,4'b1111,1,1,2,2,4'b0000), 4'b1111, 4'd1, 4'b0010, 4'd6},  // R6
    '{1'b1, cw(1,4'b0000,1,1,2,2,4'b0000), 4'b0111, 4'd3, 4'b0000, 4'd11}, // R11
    '{1'b1, cw(1,4'b1111,1,1,2,2,4'b0000), 4'b0111, 4'd1, 4'b1010, 4'd11}, // R11
    '{1'b1, cw(1,4'b1111,0,0,0,0,4'b0000), 4'b0111, 4'd1, 4'b0111, 4'd12}, // R12
    '{1'b1, cw(1,4'b1111,1,1,2,2,4'b0000), 4'b0111, 4'd1, 4'b0000, 4'd12}, // R12
    '{1'b1, cw(1,4'b1111,0,0,0,0,4'b1111), 4'b0111, 4'd1, 4'b0111, 4'd9},  // R9
    '{1'b1, cw(1,4'b1111,3,3,3,3,4'b1111), 4'b0111, 4'd1, 4'b1000, 4'd9}   // R9
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  ext_pin;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_req;
  logic        crit_normal;
  int          checks;
  int          fails;
  bit          done;

  ext_irq_sense u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_pin_i     (ext_pin),
    .reg_wr_i      (reg_wr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .irq_req_o     (irq_req),
    .crit_normal_o (crit_normal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, then step one rising edge; returns at the next falling edge
  task automatic step(input logic wr, input logic [31:0] wd, input logic [3:0] pins);
    reg_wr = wr; reg_wdata = wd; ext_pin = pins;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; ext_pin = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "rdata in reset", reg_rdata, 32'h0);
    chk("R1", "req in reset", {28'h0, irq_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req after reset", {27'h0, crit_normal, irq_req}, 32'h0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      reg_wr = VECS[v].wr; reg_wdata = VECS[v].wd; ext_pin = VECS[v].pins;
      for (int k = 0; k < int'(VECS[v].wait_n); k++) begin
        @(posedge clk);
        @(negedge clk);
        if (k == 0) reg_wr = 1'b0;
      end
      chk($sformatf("R%0d", VECS[v].tag), $sformatf("vec%0d req", v),
          {28'h0, irq_req}, {28'h0, VECS[v].exp});
      if (VECS[v].wr)  // R2 R7: readback holds fields, acknowledge bits zero
        chk("R2", $sformatf("vec%0d readback", v), reg_rdata, VECS[v].wd & RD_MASK);
    end

    // R8: acknowledge in the cycle the new edge is captured
    step(1'b1, cw(1,4'b1111,1,1,1,1,4'b0000), 4'b0000);
    repeat (2) step(1'b0, 32'h0, 4'b0000);
    chk("R8", "idle before", {28'h0, irq_req}, 32'h0);
    ext_pin = 4'b0001;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    step(1'b1, cw(1,4'b1111,1,1,1,1,4'b0001), 4'b0001);
    chk("R8", "edge beats ack", {28'h0, irq_req}, 32'h1);
    step(1'b1, cw(1,4'b1111,1,1,1,1,4'b0001), 4'b0001);
    chk("R7", "plain ack clears", {28'h0, irq_req}, 32'h0);

    // R5: level latency, two edges
    step(1'b1, cw(1,4'b1111,0,0,0,0,4'b0000), 4'b0001);
    chk("R5", "level steady", {28'h0, irq_req}, 32'h1);
    step(1'b0, 32'h0, 4'b0101);
    chk("R5", "level after 1 edge", {28'h0, irq_req}, 32'h1);
    step(1'b0, 32'h0, 4'b0101);
    chk("R5", "level after 2 edges", {28'h0, irq_req}, 32'h5);

    // R6: edge latency, three edges
    step(1'b1, cw(1,4'b1111,1,1,1,1,4'b0000), 4'b0101);
    chk("R6", "no edge yet", {28'h0, irq_req}, 32'h0);
    step(1'b0, 32'h0, 4'b0111);
    step(1'b0, 32'h0, 4'b0111);
    chk("R6", "edge after 2 edges", {28'h0, irq_req}, 32'h0);
    step(1'b0, 32'h0, 4'b0111);
    chk("R6", "edge after 3 edges", {28'h0, irq_req}, 32'h2);

    // R10: unused bits and routing bit
    step(1'b1, 32'hFFFFFFFF, 4'b0111);
    chk("R10", "all ones readback", reg_rdata, 32'h00FF1F01);
    chk("R10", "route set", {31'h0, crit_normal}, 32'h1);
    step(1'b1, 32'hA5A5A5A4, 4'b0111);
    chk("R10", "pattern readback", reg_rdata, 32'h00A50500);
    chk("R10", "route clear", {31'h0, crit_normal}, 32'h0);

    // R1: reset in mid-run
    step(1'b1, cw(1,4'b1111,0,0,0,0,4'b0000), 4'b1111);
    step(1'b0, 32'h0, 4'b1111);
    step(1'b0, 32'h0, 4'b1111);
    chk("R5", "all high", {28'h0, irq_req}, 32'hF);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset rdata", reg_rdata, 32'h0);
    chk("R1", "mid reset req", {28'h0, irq_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule